// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the architectural registers of a small 32-bit processor core. Software sees sixteen register indices, 0 to 15. Index 15 is the program counter. The other fifteen indices map onto a set of 24 general storage words. A two-bit processor mode selects which word each index reaches. The privileged modes get private copies of some indices, so an exception handler can use those registers without saving the interrupted program's values first. The total storage is 25 words of 32 bits: 24 general words plus the program counter.

The execute stage uses two combinational read ports. Port A supplies the first ALU operand. Port B supplies the operand that passes through the shifter. One synchronous write port takes the ALU result.

The fetch unit has its own port to the program counter. It can read the counter at any time and load a new value. When the ALU writes index 15, the result goes into the program counter, and a one-cycle flag tells the fetch unit to redirect.

Reads take values from storage as it stands in the current cycle, and writes land at the clock edge. This gives the ordering of a two-phase cycle, where operands are read first and the result is written back afterwards.

Top module: `bankrf_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every index reads as zero on both read ports in every mode, the program counter reads zero, and the redirect flag is low.
- R2: Mode encoding is 00 user, 01 fast interrupt, 10 interrupt, 11 supervisor. In user mode, indices 0 to 14 each reach their own storage word. A value written to index i (i below 15) is returned on a read of index i in the same mode from the next cycle on.
- R3: In fast-interrupt mode (01), indices 10 to 14 reach five private words. Writes to them are not seen from any other mode. Indices 0 to 9 are shared with user mode.
- R4: Interrupt mode (10) and supervisor mode (11) each have their own private copies of indices 13 and 14. Their indices 0 to 12 are the user-mode words.
- R5: A read of the index being written in the same cycle returns the value from before the write. The new value appears from the following cycle.
- R6: The two read ports are independent. They may address any pair of indices, including the same index, and the same index gives the same data on both.
- R7: A read of index 15 on either general port returns the current program counter in every mode.
- R8: When the program-counter write enable is high, the program counter takes the program-counter write data at the clock edge. With neither write source active, the program counter holds its value.
- R9: A general write to index 15 loads the program counter with the write data and raises the redirect flag for exactly the next cycle. It takes priority over a program-counter port write in the same cycle.
- R10: With the general write enable low, no register changes, whatever the write index and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Processor mode (00 user, 01 fast interrupt, 10 interrupt, 11 supervisor) |
| rdIdxA | input | 4 | Index for read port A |
| rdDataA | output | 32 | Read data, port A (first operand) |
| rdIdxB | input | 4 | Index for read port B |
| rdDataB | output | 32 | Read data, port B (shifter operand) |
| wrEn | input | 1 | General write enable |
| wrIdx | input | 4 | General write index |
| wrData | input | 32 | General write data (ALU result) |
| pcWrEn | input | 1 | Program-counter port write enable |
| pcWrData | input | 32 | Program-counter port write data |
| pcRdData | output | 32 | Current program counter |
| pcRedirect | output | 1 | High for one cycle after a general write to index 15 |

## Verification
The assertions check on every cycle the following behaviour, all visible at the ports:
- Index 15 aliases the program counter on both read ports.
- Both ports agree when they address the same index.
- The program counter updates correctly from the fetch port and from the ALU port, with the ALU port winning a clash.
- The redirect flag pulses for exactly one cycle.
- A write is visible the next cycle when the index and mode are unchanged.

Some behaviour is visible only through the bench's scenarios, because it needs a reference model that remembers every banked word across mode changes. This covers:
- A fast-interrupt write staying hidden from user mode.
- The interrupt and supervisor copies of indices 13 and 14 staying separate from each other.
- Shared low indices staying common to all modes.
- Disabled writes leaving every word untouched.

// File: rtl/bankrf_pkg.sv
package bankrf_pkg;

  localparam int IDX_W    = 4;
  localparam int PC_INDEX = 15;
  localparam int USR_GP   = 15;            // indices 0..14 in user view
  localparam int FIQ_CNT  = 5;             // indices 10..14 banked in FIQ
  localparam int FIQ_LO   = USR_GP - FIQ_CNT;
  localparam int SHD_CNT  = 2;             // indices 13..14 banked in IRQ/SVC
  localparam int SHD_LO   = USR_GP - SHD_CNT;
  localparam int FIQ_BASE = USR_GP;
  localparam int IRQ_BASE = FIQ_BASE + FIQ_CNT;
  localparam int SVC_BASE = IRQ_BASE + SHD_CNT;
  localparam int PHYS_GP  = SVC_BASE + SHD_CNT;   // 24 general words
  localparam int PHYS_W   = $clog2(PHYS_GP);

  typedef enum logic [1:0] {
    MODE_USR = 2'b00,
    MODE_FIQ = 2'b01,
    MODE_IRQ = 2'b10,
    MODE_SVC = 2'b11
  } cpuMode_e;

  typedef struct packed {
    logic [PHYS_W-1:0] physA;
    logic              selPcA;
    logic [PHYS_W-1:0] physB;
    logic              selPcB;
    logic              wrGen;
    logic [PHYS_W-1:0] physW;
    logic              wrPc;
    logic              pcFromAlu;
  } rfStrobes_t;

  // Architectural index (0..14) to general storage word for a mode.
  function automatic logic [PHYS_W-1:0] mapIndex(input cpuMode_e m,
                                                 input logic [IDX_W-1:0] idx);
    int unsigned i;
    int unsigned p;
    i = int'(idx);
    p = i;
    case (m)
      MODE_FIQ: if (i >= FIQ_LO && i < USR_GP) p = FIQ_BASE + (i - FIQ_LO);
      MODE_IRQ: if (i >= SHD_LO && i < USR_GP) p = IRQ_BASE + (i - SHD_LO);
      MODE_SVC: if (i >= SHD_LO && i < USR_GP) p = SVC_BASE + (i - SHD_LO);
      default:  p = i;
    endcase
    if (p >= PHYS_GP) p = 0;
    return PHYS_W'(p);
  endfunction

endpackage

// File: rtl/bankrf_ctrl.sv
module bankrf_ctrl
  import bankrf_pkg::*;
(
  input  logic [1:0]       mode,
  input  logic [IDX_W-1:0] rdIdxA,
  input  logic [IDX_W-1:0] rdIdxB,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             pcWrEn,
  output rfStrobes_t       strobes
);

  cpuMode_e curMode;
  logic     wrToPc;

  always_comb begin
    curMode = cpuMode_e'(mode);
    wrToPc  = wrEn && (wrIdx == IDX_W'(PC_INDEX));

    strobes.selPcA    = (rdIdxA == IDX_W'(PC_INDEX));
    strobes.physA     = mapIndex(curMode, rdIdxA);
    strobes.selPcB    = (rdIdxB == IDX_W'(PC_INDEX));
    strobes.physB     = mapIndex(curMode, rdIdxB);
    strobes.wrGen     = wrEn && !wrToPc;
    strobes.physW     = mapIndex(curMode, wrIdx);
    strobes.pcFromAlu = wrToPc;
    strobes.wrPc      = pcWrEn && !wrToPc;
  end

endmodule

// File: rtl/bankrf_dpath.sv
module bankrf_dpath
  import bankrf_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter logic [31:0] RESET_PC = 32'h0
)(
  input  logic              clk,
  input  logic              rst_n,
  input  rfStrobes_t        strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] pcWrData,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic [DATA_W-1:0] pcRdData,
  output logic              pcRedirect
);

  logic [DATA_W-1:0] gpWord [PHYS_GP];
  logic [DATA_W-1:0] pcWord;
  logic              redirectQ;

  for (genvar g = 0; g < PHYS_GP; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)
        gpWord[g] <= '0;
      else if (strobes.wrGen && (strobes.physW == PHYS_W'(g)))
        gpWord[g] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcWord    <= DATA_W'(RESET_PC);
      redirectQ <= 1'b0;
    end else begin
      redirectQ <= strobes.pcFromAlu;
      if (strobes.pcFromAlu)
        pcWord <= wrData;
      else if (strobes.wrPc)
        pcWord <= pcWrData;
    end
  end

  always_comb begin
    rdDataA    = strobes.selPcA ? pcWord : gpWord[strobes.physA];
    rdDataB    = strobes.selPcB ? pcWord : gpWord[strobes.physB];
    pcRdData   = pcWord;
    pcRedirect = redirectQ;
  end

endmodule

// File: rtl/bankrf_top.sv
module bankrf_top
  import bankrf_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter logic [31:0] RESET_PC = 32'h0
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [3:0]        rdIdxA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [3:0]        rdIdxB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [3:0]        wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic              pcWrEn,
  input  logic [DATA_W-1:0] pcWrData,
  output logic [DATA_W-1:0] pcRdData,
  output logic              pcRedirect
);

  rfStrobes_t strobes;

  bankrf_ctrl u_ctrl (
    .mode    (mode),
    .rdIdxA  (rdIdxA),
    .rdIdxB  (rdIdxB),
    .wrEn    (wrEn),
    .wrIdx   (wrIdx),
    .pcWrEn  (pcWrEn),
    .strobes (strobes)
  );

  bankrf_dpath #(
    .DATA_W   (DATA_W),
    .RESET_PC (RESET_PC)
  ) u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .wrData     (wrData),
    .pcWrData   (pcWrData),
    .rdDataA    (rdDataA),
    .rdDataB    (rdDataB),
    .pcRdData   (pcRdData),
    .pcRedirect (pcRedirect)
  );

endmodule

// File: rtl/bankrf_chk.sv
module bankrf_chk #(
  parameter int DATA_W = 32
)(
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode,
  input logic [3:0]        rdIdxA,
  input logic [DATA_W-1:0] rdDataA,
  input logic [3:0]        rdIdxB,
  input logic [DATA_W-1:0] rdDataB,
  input logic              wrEn,
  input logic [3:0]        wrIdx,
  input logic [DATA_W-1:0] wrData,
  input logic              pcWrEn,
  input logic [DATA_W-1:0] pcWrData,
  input logic [DATA_W-1:0] pcRdData,
  input logic              pcRedirect
);

  logic aluPcWr;
  assign aluPcWr = wrEn && (wrIdx == 4'd15);

  AST_PC_ALIAS_A: assert property (@(posedge clk) disable iff (!rst_n)
    (rdIdxA == 4'd15) |-> (rdDataA == pcRdData)); // R7
  AST_PC_ALIAS_B: assert property (@(posedge clk) disable iff (!rst_n)
    (rdIdxB == 4'd15) |-> (rdDataB == pcRdData)); // R7
  AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    (rdIdxA == rdIdxB) |-> (rdDataA == rdDataB)); // R6
  AST_PC_PORT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (pcWrEn && !aluPcWr) |=> (pcRdData == $past(pcWrData))); // R8
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!pcWrEn && !aluPcWr) |=> $stable(pcRdData)); // R8
  AST_ALU_PC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    aluPcWr |=> (pcRdData == $past(wrData)) && pcRedirect); // R9
  AST_REDIRECT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (pcRedirect && $past(rst_n)) |-> $past(aluPcWr)); // R9
  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wrEn) && ($past(wrIdx) != 4'd15) &&
     (rdIdxA == $past(wrIdx)) && (mode == $past(mode)))
    |-> (rdDataA == $past(wrData))); // R2

endmodule

bind bankrf_top bankrf_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode       (mode),
  .rdIdxA     (rdIdxA),
  .rdDataA    (rdDataA),
  .rdIdxB     (rdIdxB),
  .rdDataB    (rdDataB),
  .wrEn       (wrEn),
  .wrIdx      (wrIdx),
  .wrData     (wrData),
  .pcWrEn     (pcWrEn),
  .pcWrData   (pcWrData),
  .pcRdData   (pcRdData),
  .pcRedirect (pcRedirect)
);

// File: tb/bankrf_top_bench.sv
module bankrf_top_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode;
  logic [3:0]  rdIdxA, rdIdxB, wrIdx;
  logic [31:0] rdDataA, rdDataB, wrData, pcWrData, pcRdData;
  logic        wrEn, pcWrEn, pcRedirect;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  logic [31:0] model [24];
  logic [31:0] modelPc;
  logic        expRedir;

  always #5 clk = ~clk;

  bankrf_top u_bankrf_top (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .rdIdxA(rdIdxA), .rdDataA(rdDataA),
    .rdIdxB(rdIdxB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .pcWrEn(pcWrEn), .pcWrData(pcWrData),
    .pcRdData(pcRdData), .pcRedirect(pcRedirect)
  );

  // Word for an index below 15, from the mode table in R2..R4.
  function automatic int physOf(input logic [1:0] m, input logic [3:0] idx);
    int i = int'(idx);
    if (m == 2'b01 && i >= 10) return 15 + (i - 10);
    if (m == 2'b10 && i >= 13) return 20 + (i - 13);
    if (m == 2'b11 && i >= 13) return 22 + (i - 13);
    return i;
  endfunction

  function automatic logic [31:0] expRead(input logic [1:0] m, input logic [3:0] idx);
    if (idx == 4'd15) return modelPc;
    return model[physOf(m, idx)];
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s: got %08h expected %08h", req, what, got, exp);
    end
  endtask

  task automatic modelReset();
    for (int k = 0; k < 24; k++) model[k] = '0;
    modelPc  = '0;
    expRedir = 1'b0;
  endtask

  // One cycle: drive, check combinational reads before the edge, update model.
  task automatic step(input string req, input logic [1:0] m,
                      input logic [3:0] ia, input logic [3:0] ib,
                      input logic we, input logic [3:0] wi, input logic [31:0] wd,
                      input logic pe, input logic [31:0] pd);
    logic nextRedir;
    @(negedge clk);
    mode = m; rdIdxA = ia; rdIdxB = ib;
    wrEn = we; wrIdx = wi; wrData = wd; pcWrEn = pe; pcWrData = pd;
    #1;
    check(req, "rdDataA", rdDataA, expRead(m, ia));
    check(req, "rdDataB", rdDataB, expRead(m, ib));
    check(req, "pcRdData", pcRdData, modelPc);
    check(req, "pcRedirect", {31'b0, pcRedirect}, {31'b0, expRedir});
    @(posedge clk);
    nextRedir = we && (wi == 4'd15);
    if (nextRedir) modelPc = wd;
    else if (pe)   modelPc = pd;
    if (we && wi != 4'd15) model[physOf(m, wi)] = wd;
    expRedir = nextRedir;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    rst_n = 1'b0; mode = 2'b00; rdIdxA = 0; rdIdxB = 0;
    wrEn = 0; wrIdx = 0; wrData = 0; pcWrEn = 0; pcWrData = 0;
    modelReset();
    repeat (3) @(posedge clk);
    // R1: reset state while reset held (writes suppressed)
    @(negedge clk);
    wrEn = 1; wrIdx = 4'd3; wrData = 32'hDEAD_BEEF; pcWrEn = 1; pcWrData = 32'h1234;
    #1;
    check("R1", "rdDataA", rdDataA, 32'h0);
    check("R1", "pcRdData", pcRdData, 32'h0);
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1; wrEn = 0; pcWrEn = 0;
    for (int md = 0; md < 4; md++)
      for (int ix = 0; ix < 16; ix++)
        step("R1", 2'(md), 4'(ix), 4'(15 - ix), 1'b0, 4'd0, 32'h0, 1'b0, 32'h0);

    // R2: user write then read
    step("R2", 2'b00, 4'd0, 4'd0, 1'b1, 4'd5, 32'hA5A5_0005, 1'b0, 0);
    step("R2", 2'b00, 4'd5, 4'd5, 1'b0, 4'd0, 0, 1'b0, 0);
    // fill user 10..14
    for (int ix = 10; ix < 15; ix++)
      step("R2", 2'b00, 4'd0, 4'd0, 1'b1, 4'(ix), 32'h1000_0000 + ix, 1'b0, 0);
    // R3: FIQ writes to 11 and 3
    step("R3", 2'b01, 4'd11, 4'd3, 1'b1, 4'd11, 32'hF1F1_0011, 1'b0, 0);
    step("R3", 2'b00, 4'd11, 4'd12, 1'b0, 4'd0, 0, 1'b0, 0);
    step("R3", 2'b01, 4'd11, 4'd10, 1'b1, 4'd3, 32'hF1F1_0003, 1'b0, 0);
    step("R3", 2'b00, 4'd3, 4'd11, 1'b0, 4'd0, 0, 1'b0, 0);
    step("R3", 2'b10, 4'd11, 4'd3, 1'b0, 4'd0, 0, 1'b0, 0);
    // R4: IRQ vs SVC copies of 13/14
    step("R4", 2'b10, 4'd13, 4'd14, 1'b1, 4'd13, 32'h1111_0013, 1'b0, 0);
    step("R4", 2'b11, 4'd13, 4'd12, 1'b1, 4'd13, 32'h5555_0013, 1'b0, 0);
    step("R4", 2'b10, 4'd13, 4'd12, 1'b1, 4'd12, 32'h1111_0012, 1'b0, 0);
    step("R4", 2'b11, 4'd13, 4'd12, 1'b0, 4'd0, 0, 1'b0, 0);
    step("R4", 2'b00, 4'd13, 4'd12, 1'b0, 4'd0, 0, 1'b0, 0);
    step("R4", 2'b01, 4'd13, 4'd12, 1'b0, 4'd0, 0, 1'b0, 0);
    // R5: read of the index being written returns the old value
    step("R5", 2'b00, 4'd7, 4'd7, 1'b1, 4'd7, 32'h7777_0001, 1'b0, 0);
    step("R5", 2'b00, 4'd7, 4'd7, 1'b1, 4'd7, 32'h7777_0002, 1'b0, 0);
    step("R5", 2'b00, 4'd7, 4'd5, 1'b0, 4'd0, 0, 1'b0, 0);
    // R8: PC port load and hold
    step("R8", 2'b00, 4'd15, 4'd1, 1'b0, 4'd0, 0, 1'b1, 32'h0000_0100);
    step("R8", 2'b11, 4'd15, 4'd15, 1'b0, 4'd0, 0, 1'b0, 32'hFFFF_FFFF);
    // R9: ALU write to 15 beats the PC port, redirect for one cycle
    step("R9", 2'b10, 4'd15, 4'd2, 1'b1, 4'd15, 32'h0000_0800, 1'b1, 32'h0000_0444);
    step("R9", 2'b10, 4'd15, 4'd2, 1'b0, 4'd0, 0, 1'b0, 0);
    step("R9", 2'b10, 4'd15, 4'd2, 1'b0, 4'd0, 0, 1'b0, 0);
    // R10: disabled write with live index and data
    step("R10", 2'b01, 4'd11, 4'd3, 1'b0, 4'd11, 32'hBAD0_BAD0, 1'b0, 0);
    step("R10", 2'b01, 4'd11, 4'd15, 1'b0, 4'd15, 32'hBAD1_BAD1, 1'b0, 0);
    step("R10", 2'b01, 4'd11, 4'd15, 1'b0, 4'd0, 0, 1'b0, 0);
    // R6: random mix over all ports and modes
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] ia, ib;
      ia = 4'($urandom_range(0, 15));
      ib = ($urandom_range(0, 3) == 0) ? ia : 4'($urandom_range(0, 15));
      step("R6", 2'($urandom_range(0, 3)), ia, ib,
           1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)), $urandom(),
           ($urandom_range(0, 7) == 0), $urandom());
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule